// File: doc/BRIEF.md
# Modified Miller Frame Encoder (reader to card)

This block turns a frame description into the pause-modulation line that a proximity reader uses to talk to a Type A card. Each bit cell is a fixed number of carrier clock cycles long. Within a cell the output either carries no pause, a pause at the start of the cell, or a pause in the middle of the cell. The pause pattern chosen for each bit depends on the bit's value and on the value of the bit before it.

A frame begins with a one-cycle `start` pulse that carries the total data bit count, a short-frame flag and a flag that decides whether a parity bit follows a final byte. The data bytes then arrive over a ready/valid stream while the frame is being sent. The encoder sends a start-of-frame cell and the data bits, least significant bit first. In standard frames it adds an odd parity bit after each complete byte. It closes with the end-of-frame pair of cells and then pulses `done`. All timing is counted in carrier cycles, so the block runs directly from the carrier clock.

Top module: `pcd_miller_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `pauseOut`, `busy`, `dataReady` and `done` are all low.
- R2: Every cell lasts BIT_CYCLES clock cycles (default 128). A cell of kind Z drives `pauseOut` high for cycles 0 to PAUSE_CYCLES-1 of the cell. A cell of kind X drives it high for cycles BIT_CYCLES/2 to BIT_CYCLES/2+PAUSE_CYCLES-1 (default 64 to 91). A cell of kind Y keeps it low. The default PAUSE_CYCLES is 28.
- R3: A data or parity bit of value 1 is sent as an X cell.
- R4: A bit of value 0 is sent as a Z cell when the cell before it stood for a 0 (the start-of-frame cell counts as a 0). It is sent as a Y cell when the cell before it stood for a 1.
- R5: A `start` pulse seen while idle makes `busy` rise in the next cycle. That cycle is cycle 0 of the start-of-frame cell, which is a Z cell.
- R6: A frame ends with a cell that encodes a logic 0 under R4, followed by one Y cell. In the cycle after that Y cell ends, `done` is high for exactly one cycle and `busy` is low.
- R7: Bytes are taken in order through a one-byte buffer. A byte is transferred on a clock edge where `dataValid` and `dataReady` are both high. `dataReady` is high only during a frame, while the buffer is empty and the frame still needs more bytes. A frame needs 1 byte for a short frame, otherwise ceil(`bitCount`/8) bytes. Bit 0 of each byte is sent first.
- R8: In a standard frame, a parity bit follows every complete group of 8 data bits that is not the last group. The parity bit makes the number of ones among those 9 bits odd.
- R9: If the last data bit of a standard frame completes a byte, a parity bit follows it only when `addParity` was high at `start`. If the last data bit falls inside a byte, no parity bit follows it.
- R10: A short frame (`shortFrame` high at `start`) sends bits 0 to 6 of its single byte and no parity bit. `bitCount` and bit 7 of the byte have no effect.
- R11: A `start` pulse during a frame has no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a frame when idle |
| bitCount | input | CNT_W | Number of data bits in a standard frame, sampled at start |
| shortFrame | input | 1 | Selects the 7-bit short frame, sampled at start |
| addParity | input | 1 | Adds parity after a final complete byte, sampled at start |
| dataIn | input | 8 | Data byte of the stream |
| dataValid | input | 1 | Stream byte is valid |
| dataReady | output | 1 | Encoder can take a byte |
| pauseOut | output | 1 | Active-high pause request to the modulator |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final cell |

## Verification
Some properties are checked on every cycle. No pause may run longer than PAUSE_CYCLES, and the output and `dataReady` must stay quiet while idle. Every frame must open with a pause in its first busy cycle, and `done` must be a single pulse that coincides with the fall of `busy`. The bench's scenarios cover the behaviour that depends on the frame contents: the choice between Y and Z for zeros, the parity values, and whether a parity bit is dropped or kept at the frame end. They also show that `bitCount` and bit 7 are ignored in short frames and that a second `start` has no effect. For these, the bench compares the whole pause waveform, cell by cell, against a model built from the requirements.

// File: rtl/pcd_miller_pkg.sv
package pcd_miller_pkg;

  // Cell kinds: Y = no pause, X = mid-cell pause, Z = pause at cell start
  typedef enum logic [1:0] {
    SYM_Y = 2'd0,
    SYM_X = 2'd1,
    SYM_Z = 2'd2
  } cellKind_t;

  // Where the next cell's content comes from
  typedef enum logic [2:0] {
    SRC_SOF  = 3'd0,
    SRC_DATA = 3'd1,
    SRC_PAR  = 3'd2,
    SRC_EOF0 = 3'd3,
    SRC_EOF1 = 3'd4
  } cellSrc_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic     run;        // a frame is in progress
    logic     launch;     // begin a new cell this edge
    cellSrc_t src;        // content of the new cell
    logic     loadByte;   // new data cell takes bit 0 of the buffered byte
    logic     frameStart; // reset per-frame datapath state
  } txStrobe_t;

endpackage

// File: rtl/pcd_miller_ctrl.sv
module pcd_miller_ctrl
  import pcd_miller_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             shortFrame,
  input  logic             addParity,
  input  logic             cellEnd,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] SHORT_BITS = CNT_W'(7);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF, ST_DATA, ST_PAR, ST_EOF0, ST_EOF1
  } state_t;

  state_t           state, stateNx;
  logic [CNT_W-1:0] bitsLeft;
  logic [2:0]       bitPos;
  logic             shortReg;
  logic             parReg;
  logic             lastBit;
  logic             byteEnd;

  assign lastBit = (bitsLeft == CNT_W'(1));
  assign byteEnd = (bitPos == 3'd7);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stateNx = state;
    strobe  = '0;
    strobe.run = (state != ST_IDLE);
    strobe.src = SRC_SOF;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNx           = ST_SOF;
          strobe.launch     = 1'b1;
          strobe.src        = SRC_SOF;
          strobe.frameStart = 1'b1;
        end
      end
      ST_SOF: begin
        if (cellEnd) begin
          strobe.launch = 1'b1;
          if (bitsLeft == '0) begin
            stateNx    = ST_EOF0;
            strobe.src = SRC_EOF0;
          end else begin
            stateNx         = ST_DATA;
            strobe.src      = SRC_DATA;
            strobe.loadByte = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (cellEnd) begin
          strobe.launch = 1'b1;
          if (!shortReg && byteEnd && (!lastBit || parReg)) begin
            stateNx    = ST_PAR;
            strobe.src = SRC_PAR;
          end else if (lastBit) begin
            stateNx    = ST_EOF0;
            strobe.src = SRC_EOF0;
          end else begin
            stateNx         = ST_DATA;
            strobe.src      = SRC_DATA;
            strobe.loadByte = byteEnd;
          end
        end
      end
      ST_PAR: begin
        if (cellEnd) begin
          strobe.launch = 1'b1;
          if (bitsLeft == '0) begin
            stateNx    = ST_EOF0;
            strobe.src = SRC_EOF0;
          end else begin
            stateNx         = ST_DATA;
            strobe.src      = SRC_DATA;
            strobe.loadByte = 1'b1;
          end
        end
      end
      ST_EOF0: begin
        if (cellEnd) begin
          stateNx       = ST_EOF1;
          strobe.launch = 1'b1;
          strobe.src    = SRC_EOF1;
        end
      end
      ST_EOF1: begin
        if (cellEnd) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      bitsLeft <= '0;
      bitPos   <= '0;
      shortReg <= 1'b0;
      parReg   <= 1'b0;
    end else begin
      state <= stateNx;
      done  <= (state == ST_EOF1) && cellEnd;
      if (state == ST_IDLE && start) begin
        bitsLeft <= shortFrame ? SHORT_BITS : bitCount;
        bitPos   <= '0;
        shortReg <= shortFrame;
        parReg   <= addParity;
      end else if (state == ST_DATA && cellEnd) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
        bitPos   <= bitPos + 3'd1;
      end
    end
  end

endmodule

// File: rtl/pcd_miller_dp.sv
module pcd_miller_dp
  import pcd_miller_pkg::*;
#(
  parameter int BIT_CYCLES   = 128,
  parameter int PAUSE_CYCLES = 28,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             shortFrame,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  output logic             dataReady,
  output logic             cellEnd,
  output logic             pauseOut
);

  localparam int CELL_W = $clog2(BIT_CYCLES);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(BIT_CYCLES - 1);
  localparam logic [CELL_W-1:0] MID_ON    = CELL_W'(BIT_CYCLES / 2);
  localparam logic [CELL_W-1:0] MID_OFF   = CELL_W'(BIT_CYCLES / 2 + PAUSE_CYCLES);
  localparam logic [CELL_W-1:0] EDGE_OFF  = CELL_W'(PAUSE_CYCLES);

  logic [CELL_W-1:0] cellCnt;
  cellKind_t         curSym, nextSym;
  logic              prevZero;
  logic              parAcc;
  logic [7:0]        shiftReg;
  logic [7:0]        bufReg;
  logic              bufFull;
  logic [CNT_W-1:0]  bytesLeft;
  logic [CNT_W:0]    bitsRounded;
  logic [CNT_W-1:0]  bytesNeed;
  logic              nextBit;
  logic              accept;

  assign bitsRounded = {1'b0, bitCount} + (CNT_W+1)'(7);
  assign bytesNeed   = shortFrame ? CNT_W'(1) : CNT_W'(bitsRounded >> 3);

  assign dataReady = strobe.run && !bufFull && (bytesLeft != '0);
  assign accept    = dataValid && dataReady;
  assign cellEnd   = strobe.run && (cellCnt == CELL_LAST);

  always_comb begin
    case (strobe.src)
      SRC_DATA: nextBit = strobe.loadByte ? bufReg[0] : shiftReg[0];
      SRC_PAR:  nextBit = ~parAcc;
      default:  nextBit = 1'b0;
    endcase
    case (strobe.src)
      SRC_SOF:  nextSym = SYM_Z;
      SRC_EOF1: nextSym = SYM_Y;
      default:  nextSym = nextBit ? SYM_X : (prevZero ? SYM_Z : SYM_Y);
    endcase
  end

  always_comb begin
    case (curSym)
      SYM_Z:   pauseOut = (cellCnt < EDGE_OFF);
      SYM_X:   pauseOut = (cellCnt >= MID_ON) && (cellCnt < MID_OFF);
      default: pauseOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt  <= '0;
      curSym   <= SYM_Y;
      prevZero <= 1'b0;
      parAcc   <= 1'b0;
      shiftReg <= '0;
    end else if (strobe.launch) begin
      cellCnt <= '0;
      curSym  <= nextSym;
      if (strobe.src == SRC_SOF)       prevZero <= 1'b1;
      else if (strobe.src != SRC_EOF1) prevZero <= ~nextBit;
      if (strobe.src == SRC_DATA) begin
        parAcc   <= parAcc ^ nextBit;
        shiftReg <= strobe.loadByte ? {1'b0, bufReg[7:1]} : {1'b0, shiftReg[7:1]};
      end else if (strobe.src == SRC_PAR || strobe.src == SRC_SOF) begin
        parAcc <= 1'b0;
      end
    end else if (strobe.run) begin
      cellCnt <= cellCnt + CELL_W'(1);
    end else begin
      cellCnt <= '0;
      curSym  <= SYM_Y;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg    <= '0;
      bufFull   <= 1'b0;
      bytesLeft <= '0;
    end else if (strobe.frameStart) begin
      bufFull   <= 1'b0;
      bytesLeft <= bytesNeed;
    end else begin
      if (accept) begin
        bufReg    <= dataIn;
        bufFull   <= 1'b1;
        bytesLeft <= bytesLeft - CNT_W'(1);
      end else if (strobe.launch && strobe.loadByte) begin
        bufFull <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcd_miller_tx.sv
module pcd_miller_tx
  import pcd_miller_pkg::*;
#(
  parameter int BIT_CYCLES   = 128,
  parameter int PAUSE_CYCLES = 28,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             shortFrame,
  input  logic             addParity,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  output logic             dataReady,
  output logic             pauseOut,
  output logic             busy,
  output logic             done
);

  txStrobe_t strobe;
  logic      cellEnd;

  pcd_miller_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .bitCount   (bitCount),
    .shortFrame (shortFrame),
    .addParity  (addParity),
    .cellEnd    (cellEnd),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  pcd_miller_dp #(
    .BIT_CYCLES   (BIT_CYCLES),
    .PAUSE_CYCLES (PAUSE_CYCLES),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bitCount   (bitCount),
    .shortFrame (shortFrame),
    .dataIn     (dataIn),
    .dataValid  (dataValid),
    .dataReady  (dataReady),
    .cellEnd    (cellEnd),
    .pauseOut   (pauseOut)
  );

endmodule

// File: rtl/pcd_miller_tx_chk.sv
module pcd_miller_tx_chk #(
  parameter int PAUSE_CYCLES = 28
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic dataReady,
  input logic pauseOut,
  input logic busy,
  input logic done
);

  logic [15:0] pauseRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pauseRun <= '0;
    else if (pauseOut) pauseRun <= pauseRun + 16'd1;
    else               pauseRun <= '0;
  end

  // R2: a pause never lasts longer than PAUSE_CYCLES
  a_r2_pause_width: assert property (@(posedge clk) disable iff (!rstN)
    pauseOut |-> (pauseRun < 16'(PAUSE_CYCLES)));

  // R1: idle means no pause and no byte request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pauseOut && !dataReady));

  // R5: first busy cycle is the start of a Z cell
  a_r5_sof_pause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> pauseOut);

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: busy falls exactly when done is raised
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R11: a start during a frame never aborts it early
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

endmodule

bind pcd_miller_tx pcd_miller_tx_chk #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .dataReady (dataReady),
  .pauseOut  (pauseOut),
  .busy      (busy),
  .done      (done)
);

// File: tb/pcd_miller_tx_tb.sv
`timescale 1ns/1ps
module pcd_miller_tx_tb;

  localparam int BITC  = 128;
  localparam int PW    = 28;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] bitCount = '0;
  logic             shortFrame = 1'b0;
  logic             addParity = 1'b0;
  logic [7:0]       dataIn = '0;
  logic             dataValid = 1'b0;
  logic             dataReady, pauseOut, busy, done;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] frameBytes [0:7];
  int expSym [0:63];
  int nSym;

  always #2.5 clk = ~clk;

  pcd_miller_tx #(.BIT_CYCLES(BITC), .PAUSE_CYCLES(PW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .shortFrame(shortFrame), .addParity(addParity), .dataIn(dataIn),
    .dataValid(dataValid), .dataReady(dataReady), .pauseOut(pauseOut),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // symbol codes: 0 = Y, 1 = X, 2 = Z
  function automatic void buildExpected(input int nbits, input bit sh, input bit lp);
    bit prev0;
    bit par;
    int n;
    nSym = 0;
    expSym[nSym++] = 2;           // start-of-frame cell
    prev0 = 1'b1;
    par = 1'b0;
    n = sh ? 7 : nbits;
    for (int i = 0; i < n; i++) begin
      bit b;
      b = frameBytes[i/8][i%8];
      if (b) expSym[nSym++] = 1; else expSym[nSym++] = prev0 ? 2 : 0;
      prev0 = ~b;
      par ^= b;
      if (!sh && (i%8 == 7) && ((i != n-1) || lp)) begin
        bit p;
        p = ~par;
        if (p) expSym[nSym++] = 1; else expSym[nSym++] = prev0 ? 2 : 0;
        prev0 = ~p;
        par = 1'b0;
      end
    end
    expSym[nSym++] = prev0 ? 2 : 0; // end: logic 0
    expSym[nSym++] = 0;             // end: trailing Y
  endfunction

  function automatic bit expPause(input int s, input int off);
    if (expSym[s] == 2) return off < PW;
    if (expSym[s] == 1) return (off >= BITC/2) && (off < BITC/2 + PW);
    return 1'b0;
  endfunction

  task automatic feeder(input int nBytes);
    for (int k = 0; k < nBytes; k++) begin
      repeat ($urandom % 30) @(negedge clk);
      dataValid = 1'b1;
      dataIn = frameBytes[k];
      while (!dataReady) @(negedge clk);
      @(negedge clk);
      dataValid = 1'b0;
      dataIn = $urandom;
    end
  endtask

  task automatic monitor(input string tag, input bit inject);
    chk(dataReady === 1'b1, "R7 ready at frame start", dataReady, 1);
    for (int s = 0; s < nSym; s++) begin
      int badOff;
      int act;
      int ex;
      badOff = -1; act = 0; ex = 0;
      for (int off = 0; off < BITC; off++) begin
        int c;
        bit e;
        c = s*BITC + off;
        if (inject && c == 300) start = 1'b1;
        if (inject && c == 301) start = 1'b0;
        e = expPause(s, off);
        if ((pauseOut !== e || busy !== 1'b1 || done !== 1'b0) && badOff < 0) begin
          badOff = off; act = pauseOut; ex = e;
        end
        if (s == nSym-1 && off == BITC-1)
          chk(dataReady === 1'b0, "R7 ready low once all bytes taken", dataReady, 0);
        @(negedge clk);
      end
      if (badOff >= 0)
        $display("  cell %0d offset %0d symbol %0d", s, badOff, expSym[s]);
      chk(badOff < 0, tag, act, ex);
    end
    chk(done === 1'b1 && busy === 1'b0, "R6 done pulse at end", done, 1);
    @(negedge clk);
    chk(done === 1'b0 && pauseOut === 1'b0, "R6 R1 done single and idle", done, 0);
  endtask

  task automatic runFrame(input int nbits, input bit sh, input bit lp,
                          input logic [CNT_W-1:0] cnt, input string tag, input bit inject);
    int nBytes;
    buildExpected(nbits, sh, lp);
    nBytes = sh ? 1 : (nbits + 7) / 8;
    @(negedge clk);
    bitCount = cnt; shortFrame = sh; addParity = lp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bitCount = $urandom; shortFrame = $urandom; addParity = $urandom;
    fork
      monitor(tag, inject);
      feeder(nBytes);
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    nCmp++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pauseOut === 1'b0, "R1 reset pause", pauseOut, 0);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(dataReady === 1'b0, "R1 reset ready", dataReady, 0);
    chk(done === 1'b0, "R1 reset done", done, 0);

    // short frames, bitCount garbage and bit 7 set must be ignored (R10)
    frameBytes[0] = 8'h26;
    runFrame(7, 1'b1, 1'b0, 12'd7, "R10 R4 R5 short frame", 1'b0);
    frameBytes[0] = 8'hD2;
    runFrame(7, 1'b1, 1'b1, 12'd999, "R10 short frame ignores count and bit7", 1'b0);

    // standard frames and parity placement (R8, R9)
    frameBytes[0] = 8'h93; frameBytes[1] = 8'h20;
    runFrame(16, 1'b0, 1'b1, 12'd16, "R8 R9 two bytes with final parity", 1'b0);
    frameBytes[0] = 8'h93; frameBytes[1] = 8'h70; frameBytes[2] = 8'h15;
    runFrame(21, 1'b0, 1'b1, 12'd21, "R9 split mid-byte no parity", 1'b0);
    frameBytes[0] = 8'hA5; frameBytes[1] = 8'h3C; frameBytes[2] = 8'hF0;
    runFrame(24, 1'b0, 1'b0, 12'd24, "R9 whole bytes final parity off", 1'b0);

    // runs of zeros and ones (R3, R4)
    frameBytes[0] = 8'h00;
    runFrame(8, 1'b0, 1'b1, 12'd8, "R4 zero run after start", 1'b0);
    frameBytes[0] = 8'hFF; frameBytes[1] = 8'h01;
    runFrame(12, 1'b0, 1'b0, 12'd12, "R3 ones and odd parity", 1'b0);

    // start during a frame (R11)
    frameBytes[0] = 8'h5A; frameBytes[1] = 8'hC3;
    runFrame(16, 1'b0, 1'b1, 12'd16, "R11 start while busy ignored", 1'b1);

    // constrained random frames
    for (int f = 0; f < 12; f++) begin
      int nb;
      bit sh;
      bit lp;
      nb = 1 + ($urandom % 32);
      sh = (($urandom % 3) == 0);
      lp = $urandom % 2;
      for (int k = 0; k < 8; k++) frameBytes[k] = $urandom;
      runFrame(nb, sh, lp, sh ? CNT_W'($urandom) : CNT_W'(nb),
               "R2 R3 R4 R7 R8 R9 random frame", 1'b0);
    end

    summary();
    $finish;
  end

endmodule